// File: doc/BRIEF.md
# UART Receiver with Line Status

This block receives asynchronous serial characters on a single input line and presents them to a host one byte at a time. The line is first passed through a short synchronizer. It is then sampled on a sixteen-times baud clock enable that the surrounding logic supplies. A state machine locates the middle of the start bit and samples each later bit at its centre. It assembles the character in a shift register and hands it to a one-byte holding register, together with its parity, stop-bit and break verdicts.

The host sees the holding register on one output and an eight-bit status byte on another. A one-cycle strobe marks each read of the holding register and each read of the status byte. Error conditions feed a level interrupt request, which is gated by one static enable input. Word length, parity on/off and type, and stop-bit count are static configuration inputs.

Top module: `uart_rx_lsr`

## Requirements
- R1: The received word is stored right-justified with the first serial bit in bit 0 and unused upper bits zero. The word length code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits, and the holding register changes only when a character is accepted.
- R2: Status bit 0 (ready) is set when a character is loaded into the holding register and is cleared by a holding-register read strobe.
- R3: With parity enabled, one parity bit follows the data. With the even type selected, the data ones plus the parity bit must total an even count; with the odd type, an odd count. A mismatch sets status bit 2.
- R4: If any configured stop bit (one, or two when the two-stop input is high) is sampled low, status bit 3 is set for that character.
- R5: If a character completes while bit 0 is set and no holding-register read occurs in that cycle, status bit 1 is set. The new character is dropped and the holding register keeps its byte.
- R6: A frame sampled low from start bit through the last stop bit loads one 0x00 character with status bits 4 and 3 set. A frame whose final stop bit is low leaves the receiver disarmed until the line is high again, so a long low level yields only one character.
- R7: Status bit 4 survives status reads for as long as the line stays low after the break. The first status read after the line returns high clears it.
- R8: A status read strobe clears bits 1, 2 and 3 (and bit 4 per R7) and leaves bit 0 alone. Bits 7 to 5 always read 0.
- R9: The interrupt output is high exactly when the enable input is high and any of status bits 1 to 4 is set. Parity, framing and break raise it as the character lands; overrun raises it on the next clock.
- R10: A start bit is accepted only if the line reads low on nine consecutive sample enables, which ends at mid start bit. A shorter low pulse produces no character.
- R11: After reset the status byte, the holding register and the interrupt output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sixteen-times baud sample enable |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Word length code, 5 + code data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | 1 = two stop bits checked |
| lsi_en | input | 1 | Line-status interrupt enable |
| rd_data | input | 1 | Holding-register read strobe |
| rd_stat | input | 1 | Status read strobe |
| rx_data | output | 8 | Holding register |
| line_status | output | 8 | Status byte: ready, overrun, parity, framing, break in bits 0 to 4 |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
The hardest state to reach is the break hold-off. The line must stay low well past one full frame, a status read must happen while the receiver waits for mark, and a clean character must follow to show that it re-arms. The bench holds the line low for two frame lengths and reads status mid-hold. It then releases the line, reads again and sends a normal byte. Overrun is reached by sending two frames with no read between them. The sweep covers every word length, parity mode and stop count, with one deliberately corrupted frame per configuration.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DW = 8;

  localparam int unsigned ST_DR = 0;
  localparam int unsigned ST_OE = 1;
  localparam int unsigned ST_PE = 2;
  localparam int unsigned ST_FE = 3;
  localparam int unsigned ST_BI = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_t;

  // index of the final data bit for a word length code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wl);
    return {1'b0, wl} + 3'd4;
  endfunction

  // bits enter at the top of the shifter; short words need a right shift
  function automatic logic [DW-1:0] align_word(input logic [DW-1:0] sh, input logic [1:0] wl);
    return sh >> (3'd3 - {1'b0, wl});
  endfunction

  function automatic logic parity_bit(input logic [DW-1:0] d, input logic even);
    return even ? ^d : ~(^d);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          cfg_stop2,
  output logic          frame_done,
  output logic [DW-1:0] f_data,
  output logic          f_pe,
  output logic          f_fe,
  output logic          f_brk,
  output logic          line_held
);
  localparam int unsigned CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [DW-1:0] sh;
  logic          pbit, stop_bad, all_low, sidx;
  logic [DW-1:0] word;
  logic          at_bit;

  assign word   = align_word(sh, cfg_wlen);
  assign at_bit = (cnt == CNT_FULL);
  assign line_held = (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0; pbit <= 1'b0;
      stop_bad <= 1'b0; all_low <= 1'b0; sidx <= 1'b0;
      frame_done <= 1'b0; f_data <= '0; f_pe <= 1'b0; f_fe <= 1'b0; f_brk <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rxd) begin st <= S_START; cnt <= '0; end
          S_START: begin
            if (rxd) st <= S_IDLE;
            else if (cnt == CNT_HALF) begin
              st <= S_DATA; cnt <= '0; bidx <= '0; sh <= '0;
              all_low <= 1'b1; stop_bad <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            cnt <= cnt + 1'b1;
            if (at_bit) begin
              sh <= {rxd, sh[DW-1:1]};
              all_low <= all_low & ~rxd;
              if (bidx == last_bit_idx(cfg_wlen)) begin
                st <= cfg_par_en ? S_PAR : S_STOP; sidx <= 1'b0;
              end else bidx <= bidx + 1'b1;
            end
          end
          S_PAR: begin
            cnt <= cnt + 1'b1;
            if (at_bit) begin
              pbit <= rxd; all_low <= all_low & ~rxd; st <= S_STOP; sidx <= 1'b0;
            end
          end
          S_STOP: begin
            cnt <= cnt + 1'b1;
            if (at_bit) begin
              if (cfg_stop2 && !sidx) begin
                sidx <= 1'b1; stop_bad <= stop_bad | ~rxd; all_low <= all_low & ~rxd;
              end else begin
                frame_done <= 1'b1;
                f_data <= word;
                f_pe   <= cfg_par_en && (pbit != parity_bit(word, cfg_par_even));
                f_fe   <= stop_bad | ~rxd;
                f_brk  <= all_low & ~rxd;
                st     <= rxd ? S_IDLE : S_HOLD;
              end
            end
          end
          S_HOLD: if (rxd) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] f_data,
  input  logic          f_pe,
  input  logic          f_fe,
  input  logic          f_brk,
  input  logic          line_held,
  input  logic          rd_data,
  input  logic          rd_stat,
  input  logic          irq_en,
  output logic [DW-1:0] hold,
  output logic [7:0]    status,
  output logic          irq
);
  logic dr, oe, pe, fe, bi;
  logic accept, overrun;

  assign accept  = frame_done && (!dr || rd_data);
  assign overrun = frame_done && dr && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0; dr <= 1'b0; oe <= 1'b0; pe <= 1'b0; fe <= 1'b0; bi <= 1'b0;
    end else begin
      if (accept) hold <= f_data;

      if (accept)       dr <= 1'b1;
      else if (rd_data) dr <= 1'b0;

      if (overrun)      oe <= 1'b1;
      else if (rd_stat) oe <= 1'b0;

      if (accept && f_pe) pe <= 1'b1;
      else if (rd_stat)   pe <= 1'b0;

      if (accept && f_fe) fe <= 1'b1;
      else if (rd_stat)   fe <= 1'b0;

      if (accept && f_brk)              bi <= 1'b1;
      else if (rd_stat && !line_held)   bi <= 1'b0;
    end
  end

  always_comb begin
    status        = '0;
    status[ST_DR] = dr;
    status[ST_OE] = oe;
    status[ST_PE] = pe;
    status[ST_FE] = fe;
    status[ST_BI] = bi;
  end

  assign irq = irq_en && (oe || pe || fe || bi);
endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  input  logic       lsi_en,
  input  logic       rd_data,
  input  logic       rd_stat,
  output logic [7:0] rx_data,
  output logic [7:0] line_status,
  output logic       lsi_irq
);
  logic          rxd_s;
  logic          frame_done, line_held;
  logic [DW-1:0] f_data;
  logic          f_pe, f_fe, f_brk;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd(rxd_s),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .frame_done(frame_done), .f_data(f_data),
    .f_pe(f_pe), .f_fe(f_fe), .f_brk(f_brk), .line_held(line_held)
  );

  uart_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .f_data(f_data),
    .f_pe(f_pe), .f_fe(f_fe), .f_brk(f_brk), .line_held(line_held),
    .rd_data(rd_data), .rd_stat(rd_stat), .irq_en(lsi_en),
    .hold(rx_data), .status(line_status), .irq(lsi_irq)
  );
endmodule

// File: rtl/uart_rx_lsr_chk.sv
module uart_rx_lsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_done,
  input logic       line_held,
  input logic       rd_data,
  input logic       rd_stat,
  input logic       lsi_en,
  input logic       lsi_irq,
  input logic [7:0] rx_data,
  input logic [7:0] line_status
);
  assert_overrun_keeps_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && line_status[0] && !rd_data) |=> ($stable(rx_data) && line_status[1]));

  assert_overrun_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && line_status[0] && !rd_data && lsi_en) |=> lsi_irq);

  assert_ready_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !frame_done) |=> !line_status[0]);

  assert_break_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_held && line_status[4]) |=> line_status[4]);

  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !frame_done) |=> (line_status[3:1] == 3'b000));
endmodule

bind uart_rx_lsr uart_rx_lsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .line_held(line_held),
  .rd_data(rd_data), .rd_stat(rd_stat), .lsi_en(lsi_en), .lsi_irq(lsi_irq),
  .rx_data(rx_data), .line_status(line_status)
);

// File: tb/uart_rx_lsr_bench.sv
module uart_rx_lsr_bench;
  localparam int BIT = 32;  // 16 sample enables, one every two clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_stop2 = 1'b0;
  logic lsi_en = 1'b1, rd_data = 1'b0, rd_stat = 1'b0;
  logic [7:0] rx_data, line_status;
  logic lsi_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  uart_rx_lsr u_uart_rx_lsr (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .lsi_en(lsi_en), .rd_data(rd_data), .rd_stat(rd_stat),
    .rx_data(rx_data), .line_status(line_status), .lsi_irq(lsi_irq)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    sample_en = ~sample_en;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input logic v, input int n);
    rxd = v;
    repeat (n * BIT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input int bad_stop);
    int nb = 5 + int'(cfg_wlen);
    logic [7:0] m = 8'((1 << nb) - 1) & d;
    logic p = cfg_par_even ? ^m : ~(^m);
    hold_bits(1'b0, 1);
    for (int i = 0; i < nb; i++) hold_bits(m[i], 1);
    if (cfg_par_en) hold_bits(bad_par ? ~p : p, 1);
    for (int s = 1; s <= (cfg_stop2 ? 2 : 1); s++) hold_bits(bad_stop == s ? 1'b0 : 1'b1, 1);
    hold_bits(1'b1, 2);
  endtask

  task automatic pulse_stat();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_data();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check("R11 status", int'(line_status), 0);
    check("R11 data", int'(rx_data), 0);
    check("R11 irq", int'(lsi_irq), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep: word length x parity mode x stop count, three clean frames and one corrupted
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 3; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] d, exp_d;
            bit bp;
            int bs, exp_st;
            cfg_wlen = 2'(wl); cfg_par_en = (pm != 0); cfg_par_even = (pm == 2); cfg_stop2 = s2[0];
            d = (k == 0) ? 8'h96 : (k == 1) ? 8'h3C : 8'((wl * 53 + pm * 29 + s2 * 7 + k * 71) | 1);
            bp = (k == 3) && (pm != 0);
            bs = ((k == 3) && (pm == 0)) ? (s2 ? 2 : 1) : 0;
            send(d, bp, bs);
            exp_d = d & 8'((1 << (5 + wl)) - 1);
            exp_st = 1 | (bp ? 4 : 0) | (bs != 0 ? 8 : 0);
            check("R1 data", int'(rx_data), int'(exp_d));
            check("R2/R3/R4 status", int'(line_status), exp_st);
            check("R9 irq", int'(lsi_irq), (exp_st & 30) != 0 ? 1 : 0);
            pulse_stat();
            check("R8 status after status read", int'(line_status), 1);
            pulse_data();
            check("R2 status after data read", int'(line_status), 0);
          end

    // R5 overrun
    cfg_wlen = 2'd3; cfg_par_en = 0; cfg_par_even = 0; cfg_stop2 = 0;
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    check("R5 data kept", int'(rx_data), 'h11);
    check("R5 status", int'(line_status), 'h03);
    check("R9 irq on overrun", int'(lsi_irq), 1);
    pulse_stat();
    check("R8 overrun cleared", int'(line_status), 'h01);
    check("R9 irq drops", int'(lsi_irq), 0);
    pulse_data();

    // R9 disabled interrupt with parity error
    lsi_en = 0; cfg_par_en = 1;
    send(8'h7E, 1, 0);
    check("R3 parity error flagged", int'(line_status), 'h05);
    check("R9 irq masked", int'(lsi_irq), 0);
    pulse_stat(); pulse_data();
    lsi_en = 1; cfg_par_en = 0;

    // R6/R7 break
    hold_bits(1'b0, 20);
    check("R6 break data", int'(rx_data), 0);
    check("R6 single break char", int'(line_status), 'h19);
    check("R9 irq on break", int'(lsi_irq), 1);
    pulse_stat();
    check("R7 break held while low", int'(line_status), 'h11);
    hold_bits(1'b1, 2);
    check("R7 break kept until read", int'(line_status), 'h11);
    pulse_stat();
    check("R7 break cleared after mark", int'(line_status), 'h01);
    pulse_data();
    send(8'h5A, 0, 0);
    check("R6 rearmed data", int'(rx_data), 'h5A);
    check("R6 rearmed status", int'(line_status), 'h01);
    pulse_data();

    // R10 false starts
    rxd = 1'b0; repeat (8) @(negedge clk);
    hold_bits(1'b1, 3);
    check("R10 short pulse", int'(line_status), 0);
    rxd = 1'b0; repeat (14) @(negedge clk);
    hold_bits(1'b1, 3);
    check("R10 under half bit", int'(line_status), 0);
    send(8'hC3, 0, 0);
    check("R10 next frame data", int'(rx_data), 'hC3);
    pulse_data();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule